// File: doc/BRIEF.md
# Two-Lane Block Exchange Unit

This unit is a streaming reorder element for the data path between folded FFT stages. Each accepted cycle it takes one word on each of two input lanes and returns one word on each of two output lanes. Fixed lane-wiring permutations on either side of it complete a full stride permutation. The unit works in blocks of `DEPTH` accepted steps. Per pair of blocks, it keeps the first lane-0 block and the second lane-1 block on their own lanes, and it exchanges the first lane-1 block with the second lane-0 block. This is a 2x2 block transpose.

Inside are two delay FIFOs of `DEPTH` entries each and a 2x2 switch. One FIFO delays lane 1 ahead of the switch. The other delays the switch's lane-0 output. The switch alternates between straight routing and crossed routing, and it holds each mode for `DEPTH` accepted steps. A step is a clock edge with `in_valid` high. When `in_valid` is low, the unit freezes and no state advances, so the upstream stage may leave gaps in its stream.

Top module: `lane_swap_unit`

## Requirements
- R1: While reset is held and in the first cycles after it, `out_valid` is 0. The switch restarts in straight mode with both FIFOs empty.
- R2: Number the accepted steps k = 0, 1, 2, ... from reset. In the same cycle as step k, `out_valid` equals `in_valid` AND (k >= DEPTH).
- R3: The routing follows the phase j = k mod (2*DEPTH). Phases 0..DEPTH-1 are straight and phases DEPTH..2*DEPTH-1 are crossed, and the two modes alternate indefinitely.
- R4: At a valid crossed step k, `out_lane0` equals lane-0 input of step k-DEPTH and `out_lane1` equals lane-0 input of step k (same cycle).
- R5: At a valid straight step k (k >= 2*DEPTH), `out_lane0` equals lane-1 input of step k-2*DEPTH and `out_lane1` equals lane-1 input of step k-DEPTH.
- R6: A cycle with `in_valid` low drives `out_valid` low and advances neither the phase nor the FIFOs. The output sequence over accepted steps is the same as in a stream without gaps.
- R7: A reset asserted mid-stream discards all held words. Numbering of k restarts at 0 and R2 to R5 apply again from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Both input lanes carry a word this cycle |
| in_lane0 | input | WIDTH | Input word, lane 0 |
| in_lane1 | input | WIDTH | Input word, lane 1 |
| out_valid | output | 1 | Both output lanes carry a word this cycle |
| out_lane0 | output | WIDTH | Output word, lane 0 |
| out_lane1 | output | WIDTH | Output word, lane 1 |

## Verification
On every cycle the assertions check four things. They check that the switch mode matches an independently counted step phase, and that the mode holds through idle cycles. They check that `out_valid` tracks the fill count and drops in idle cycles. They check that a crossed step routes the lane-0 input straight to output lane 1. The delayed word positions are different: which stored word appears on which lane, across whole block pairs, gaps and a mid-stream reset, is shown only by the bench's indexed streams. The bench compares those streams against the arithmetic block-transpose model for two FIFO depths.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
  typedef enum logic {
    ROUTE_PASS  = 1'b0,
    ROUTE_CROSS = 1'b1
  } route_e;
endpackage

// File: rtl/lsw_rst_sync.sv
module lsw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/lsw_delay.sv
module lsw_delay #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [DEPTH];
  logic [WIDTH-1:0] stage_d [DEPTH];

  // Shift-register FIFO: each slot takes its upstream neighbour
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign stage_d[i] = din;
    end else begin : g_body
      assign stage_d[i] = stage_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
    end else if (shift_en) begin
      for (int i = 0; i < DEPTH; i++) stage_q[i] <= stage_d[i];
    end
  end

  assign dout = stage_q[DEPTH-1];
endmodule

// File: rtl/lsw_phase.sv
module lsw_phase
  import lsw_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   step,
  output route_e route,
  output logic   filled
);
  localparam int CW = (DEPTH > 1) ? $clog2(2 * DEPTH) : 1;
  localparam logic [CW-1:0] LAST_PHASE = CW'(2 * DEPTH - 1);
  localparam logic [CW-1:0] FILL_PHASE = CW'(DEPTH - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          filled_q, filled_d;

  always_comb begin
    cnt_d    = (cnt_q == LAST_PHASE) ? '0 : cnt_q + 1'b1;
    filled_d = filled_q | (cnt_q == FILL_PHASE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      filled_q <= 1'b0;
    end else if (step) begin
      cnt_q    <= cnt_d;
      filled_q <= filled_d;
    end
  end

  // Upper half of the 2*DEPTH phase range is the crossed block
  assign route  = cnt_q[CW-1] ? ROUTE_CROSS : ROUTE_PASS;
  assign filled = filled_q;
endmodule

// File: rtl/lsw_xbar.sv
module lsw_xbar
  import lsw_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  route_e           route,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] b_out
);
  always_comb begin
    if (route == ROUTE_CROSS) begin
      a_out = b_in;
      b_out = a_in;
    end else begin
      a_out = a_in;
      b_out = b_in;
    end
  end
endmodule

// File: rtl/lane_swap_unit.sv
module lane_swap_unit
  import lsw_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_lane0,
  input  logic [WIDTH-1:0] in_lane1,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_lane0,
  output logic [WIDTH-1:0] out_lane1
);
  logic             rst_sync_n;
  route_e           route;
  logic             filled;
  logic [WIDTH-1:0] lane1_dly;
  logic [WIDTH-1:0] sw_lane0;
  logic [WIDTH-1:0] sw_lane1;

  lsw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lsw_phase #(.DEPTH(DEPTH)) u_phase (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .step   (in_valid),
    .route  (route),
    .filled (filled)
  );

  lsw_delay #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_pre_fifo (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .shift_en (in_valid),
    .din      (in_lane1),
    .dout     (lane1_dly)
  );

  lsw_xbar #(.WIDTH(WIDTH)) u_xbar (
    .route (route),
    .a_in  (in_lane0),
    .b_in  (lane1_dly),
    .a_out (sw_lane0),
    .b_out (sw_lane1)
  );

  lsw_delay #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_post_fifo (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .shift_en (in_valid),
    .din      (sw_lane0),
    .dout     (out_lane0)
  );

  assign out_lane1 = sw_lane1;
  assign out_valid = in_valid & filled;
endmodule

// File: rtl/lane_swap_unit_chk.sv
module lane_swap_unit_chk #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [WIDTH-1:0] in_lane0,
  input logic             out_valid,
  input logic [WIDTH-1:0] out_lane1,
  input logic             route_cross
);
  localparam int CW = $clog2(2 * DEPTH + 1);

  logic [CW-1:0] phase_q;
  logic [CW-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      seen_q  <= '0;
    end else if (in_valid) begin
      phase_q <= (phase_q == CW'(2 * DEPTH - 1)) ? '0 : phase_q + 1'b1;
      if (seen_q < CW'(DEPTH)) seen_q <= seen_q + 1'b1;
    end
  end

  a_r3_mode_follows_phase: assert property (@(posedge clk) disable iff (!rst_n)
    route_cross == (phase_q >= CW'(DEPTH)));

  a_r6_mode_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(route_cross));

  a_r6_no_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !out_valid);

  a_r2_fill_gate: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == (in_valid && (seen_q >= CW'(DEPTH))));

  a_r4_cross_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && route_cross) |-> (out_lane1 == in_lane0));
endmodule

bind lane_swap_unit lane_swap_unit_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .in_valid    (in_valid),
  .in_lane0    (in_lane0),
  .out_valid   (out_valid),
  .out_lane1   (out_lane1),
  .route_cross (route == lsw_pkg::ROUTE_CROSS)
);

// File: tb/lane_swap_unit_tb_top.sv
`timescale 1ns/1ps
module lane_swap_unit_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in0 = '0;
  logic [W-1:0] in1 = '0;
  logic         ov4, ov2;
  logic [W-1:0] o04, o14, o02, o12;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit after_rst = 1'b0;
  int k = 0;
  logic [W-1:0] a_hist [256];
  logic [W-1:0] b_hist [256];

  always #4 clk = ~clk;

  lane_swap_unit #(.WIDTH(W), .DEPTH(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_lane0(in0), .in_lane1(in1),
    .out_valid(ov4), .out_lane0(o04), .out_lane1(o14));

  lane_swap_unit #(.WIDTH(W), .DEPTH(2)) dut_m2 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_lane0(in0), .in_lane1(in1),
    .out_valid(ov2), .out_lane0(o02), .out_lane1(o12));

  task automatic chk(input string tag, input int m, input logic [W-1:0] got,
                     input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s depth=%0d step=%0d got=%h exp=%h", tag, m, k, got, exp);
    end
  endtask

  // Model of the block transpose for one FIFO depth
  task automatic check_model(input int m, input logic v, input logic [W-1:0] g0,
                             input logic [W-1:0] g1);
    int j;
    string pfx;
    pfx = after_rst ? "R7 " : "";
    chk({pfx, "R2 out_valid"}, m, W'(v), W'(k >= m));
    if (k >= m) begin
      j = k % (2 * m);
      if (j >= m) begin
        chk({pfx, "R3/R4 crossed lane0"}, m, g0, a_hist[k-m]);
        chk({pfx, "R3/R4 crossed lane1"}, m, g1, a_hist[k]);
      end else begin
        chk({pfx, "R3/R5 straight lane0"}, m, g0, b_hist[k-2*m]);
        chk({pfx, "R3/R5 straight lane1"}, m, g1, b_hist[k-m]);
      end
    end
  endtask

  task automatic step(input logic [W-1:0] base_a, input logic [W-1:0] base_b);
    @(negedge clk);
    in_valid = 1'b1;
    in0 = base_a + W'(k);
    in1 = base_b + W'(k);
    a_hist[k] = in0;
    b_hist[k] = in1;
    #1;
    check_model(4, ov4, o04, o14);
    check_model(2, ov2, o02, o12);
    @(posedge clk);
    k++;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in0 = 16'hDEAD;
    in1 = 16'hBEEF;
    #1;
    chk("R6 idle out_valid d4", 4, W'(ov4), '0);
    chk("R6 idle out_valid d2", 2, W'(ov2), '0);
    @(posedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset out_valid d4", 4, W'(ov4), '0);
    chk("R1 reset out_valid d2", 2, W'(ov2), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    k = 0;
  endtask

  initial begin
    do_reset();
    for (int n = 0; n < 40; n++) begin
      if (n % 7 == 3) idle();
      step(16'h0000, 16'h8000);
    end
    // Partial block, then reset mid-stream
    for (int n = 0; n < 3; n++) step(16'h1000, 16'h9000);
    do_reset();
    after_rst = 1'b1;
    for (int n = 0; n < 24; n++) begin
      if (n % 5 == 1) begin idle(); idle(); end
      step(16'h4000, 16'hC000);
    end
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule